// File: doc/BRIEF.md
# Link Receiver with Block Descriptor Queue

This block sits on a shared point-to-point link in front of one processing element. Every link word carries a destination mask. The word is written into the element's local data FIFO when the mask bit for this element is set, and it is passed on downstream when any other mask bit is set. A word may be both written and passed on. The hold line sent upstream is raised only for the resources that the current word actually needs: the local queue or data FIFO when the word is for this element, and the downstream hold when the word must be passed on.

Each accepted word adds one to a count of words in the current input block. When an accepted word carries the block-complete marker, the block is closed. A 32-bit descriptor holding the block's word count and source channel is then pushed into a 16-entry queue. One event produces one descriptor per input block, so one event can place several entries in the queue. The queue drains to the processor over a serial port, one 32-bit frame per descriptor, and each frame begins with a frame-sync pulse.

Top module: `link_rx_desc`

## Requirements
- R1: After reset, hold_up, out_valid, fifo_wr and ser_vld are all 0.
- R2: fifo_wr is high in the same cycle as in_valid when bit MY_ID (default 1) of in_dest is set and hold_up is low. fifo_wdata then equals in_data. A word whose bit MY_ID is clear is never written.
- R3: out_valid is high in the same cycle as in_valid when in_dest has a set bit other than bit MY_ID and hold_up is low. out_data equals in_data, and out_dest equals in_dest with bit MY_ID cleared.
- R4: hold_up = in_valid and ((bit MY_ID set and (queue level at least 15 or fifo_afull)) or (another bit set and dn_hold)). While hold_up is high, neither fifo_wr nor out_valid is asserted.
- R5: The word count in a descriptor is the number of accepted words in the block, including the word that closes it. The count saturates at 0xFFFF.
- R6: The descriptor layout is: bit 31 is 1, bits 30:20 are 0, bits 19:16 hold in_src of the closing word, and bits 15:0 hold the word count.
- R7: Exactly one descriptor is queued for each accepted word that has in_last set. Words for other elements neither count nor queue.
- R8: The queue holds 16 descriptors and delivers them in arrival order. It never overflows, and it loses none.
- R9: Each frame is sent MSB first as 32 consecutive bits with ser_vld high. ser_fs is high only on the first bit. Frames are separated by at least one idle cycle.
- R10: With the queue empty and the port idle, the first bit of a descriptor appears in the cycle after the clock edge that follows the edge accepting its closing word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Upstream word present |
| in_data | input | DATA_W | Upstream data word |
| in_dest | input | DEST_W | Destination mask |
| in_src | input | 4 | Source channel of the word |
| in_last | input | 1 | Block-complete marker |
| hold_up | output | 1 | Hold toward upstream |
| out_valid | output | 1 | Word passed downstream |
| out_data | output | DATA_W | Downstream data |
| out_dest | output | DEST_W | Downstream mask, own bit cleared |
| out_src | output | 4 | Downstream source channel |
| out_last | output | 1 | Downstream block marker |
| dn_hold | input | 1 | Hold from downstream |
| fifo_wr | output | 1 | Data FIFO write strobe |
| fifo_wdata | output | DATA_W | Data FIFO write data |
| fifo_last | output | 1 | Block marker stored with the data |
| fifo_afull | input | 1 | Data FIFO almost full |
| ser_vld | output | 1 | Serial bit valid |
| ser_fs | output | 1 | Frame sync, first bit only |
| ser_dat | output | 1 | Serial data bit |

## Verification
The filter outputs, fifo_wr, out_valid, out_dest and hold_up, are combinational. The bench therefore checks them one time unit after it drives the inputs, before the next rising edge. A descriptor enters the queue at the edge that accepts its closing word. With the port idle, the first serial bit is due just after the following edge, and the bench samples at exactly that point for R10. Serial frames are collected 2 ns after each rising edge and compared, in order, against descriptors that the bench builds from its own count of accepted words.

// File: rtl/link_rx_pkg.sv
package link_rx_pkg;
  localparam int DESC_W = 32;
  localparam int CNT_W  = 16;
  localparam int SRC_W  = 4;

  // Increment that sticks at the top value.
  function automatic logic [CNT_W-1:0] sat_inc(input logic [CNT_W-1:0] c);
    return (c == {CNT_W{1'b1}}) ? c : c + 1'b1;
  endfunction

  // Descriptor: valid flag in bit 31, source in 19:16, count in 15:0.
  function automatic logic [DESC_W-1:0] make_desc(input logic [SRC_W-1:0] src,
                                                  input logic [CNT_W-1:0] cnt);
    return {1'b1, {(DESC_W-1-SRC_W-CNT_W){1'b0}}, src, cnt};
  endfunction
endpackage

// File: rtl/link_rx_filter.sv
module link_rx_filter #(
  parameter int DEST_W   = 4,
  parameter int MY_ID    = 1,
  parameter int LVL_W    = 5,
  parameter int HOLD_LVL = 15
) (
  input  logic              in_valid,
  input  logic [DEST_W-1:0] in_dest,
  input  logic [LVL_W-1:0]  q_level,
  input  logic              fifo_afull,
  input  logic              dn_hold,
  output logic              hold_up,
  output logic              take_local,
  output logic              pass_on,
  output logic [DEST_W-1:0] pass_dest
);
  localparam logic [DEST_W-1:0] OWN_MASK = DEST_W'(1) << MY_ID;

  logic own_hit, other_hit, local_stall;

  always_comb begin
    own_hit     = in_dest[MY_ID];
    other_hit   = |(in_dest & ~OWN_MASK);
    local_stall = (q_level >= LVL_W'(HOLD_LVL)) | fifo_afull;
    hold_up     = in_valid & ((own_hit & local_stall) | (other_hit & dn_hold));
    take_local  = in_valid & ~hold_up & own_hit;
    pass_on     = in_valid & ~hold_up & other_hit;
    pass_dest   = in_dest & ~OWN_MASK;
  end
endmodule

// File: rtl/link_rx_count.sv
module link_rx_count
  import link_rx_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              acc,
  input  logic              last,
  input  logic [SRC_W-1:0]  src,
  output logic              push,
  output logic [DESC_W-1:0] desc
);
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_nx;

  always_comb begin
    cnt_nx = sat_inc(cnt_q);
    push   = acc & last;
    desc   = make_desc(src, cnt_nx);
  end

  always_ff @(posedge clk) begin
    if (rst)      cnt_q <= '0;
    else if (acc) cnt_q <= last ? '0 : cnt_nx;
  end
endmodule

// File: rtl/link_rx_queue.sv
module link_rx_queue #(
  parameter int W     = 32,
  parameter int DEPTH = 16,
  localparam int AW   = $clog2(DEPTH),
  localparam int LW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          push,
  input  logic [W-1:0]  din,
  input  logic          pop,
  output logic [W-1:0]  dout,
  output logic          empty,
  output logic          full,
  output logic [LW-1:0] level
);
  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp, rp;

  assign dout  = mem[rp];
  assign empty = (level == '0);
  assign full  = (level == LW'(DEPTH));

  always_ff @(posedge clk) begin
    if (push && !full) mem[wp] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wp    <= '0;
      rp    <= '0;
      level <= '0;
    end else begin
      if (push && !full) wp <= wp + 1'b1;
      if (pop && !empty) rp <= rp + 1'b1;
      level <= level + LW'(push && !full) - LW'(pop && !empty);
    end
  end
endmodule

// File: rtl/link_rx_ser.sv
module link_rx_ser #(
  parameter int W  = 32,
  localparam int BW = $clog2(W)
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         q_empty,
  input  logic [W-1:0] q_head,
  output logic         q_pop,
  output logic         ser_vld,
  output logic         ser_fs,
  output logic         ser_dat
);
  logic          busy;
  logic [W-1:0]  sreg;
  logic [BW-1:0] bitn;

  assign q_pop   = ~busy & ~q_empty;
  assign ser_vld = busy;
  assign ser_fs  = busy & (bitn == '0);
  assign ser_dat = busy & sreg[W-1];

  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b0;
      sreg <= '0;
      bitn <= '0;
    end else if (!busy) begin
      if (!q_empty) begin
        busy <= 1'b1;
        sreg <= q_head;
        bitn <= '0;
      end
    end else begin
      sreg <= sreg << 1;
      bitn <= bitn + 1'b1;
      if (bitn == BW'(W - 1)) busy <= 1'b0;
    end
  end
endmodule

// File: rtl/link_rx_desc.sv
module link_rx_desc
  import link_rx_pkg::*;
#(
  parameter int DATA_W   = 32,
  parameter int DEST_W   = 4,
  parameter int MY_ID    = 1,
  parameter int QDEPTH   = 16,
  parameter int HOLD_LVL = 15
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_data,
  input  logic [DEST_W-1:0] in_dest,
  input  logic [SRC_W-1:0]  in_src,
  input  logic              in_last,
  output logic              hold_up,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_data,
  output logic [DEST_W-1:0] out_dest,
  output logic [SRC_W-1:0]  out_src,
  output logic              out_last,
  input  logic              dn_hold,
  output logic              fifo_wr,
  output logic [DATA_W-1:0] fifo_wdata,
  output logic              fifo_last,
  input  logic              fifo_afull,
  output logic              ser_vld,
  output logic              ser_fs,
  output logic              ser_dat
);
  localparam int LW = $clog2(QDEPTH + 1);

  // Internal events, named for the checker.
  logic              q_push, q_pop, q_empty, q_full;
  logic [DESC_W-1:0] q_din, q_head;
  logic [LW-1:0]     q_level;

  link_rx_filter #(.DEST_W(DEST_W), .MY_ID(MY_ID), .LVL_W(LW), .HOLD_LVL(HOLD_LVL)) filt_i (
    .in_valid(in_valid), .in_dest(in_dest), .q_level(q_level),
    .fifo_afull(fifo_afull), .dn_hold(dn_hold), .hold_up(hold_up),
    .take_local(fifo_wr), .pass_on(out_valid), .pass_dest(out_dest));

  assign out_data   = in_data;
  assign out_src    = in_src;
  assign out_last   = in_last;
  assign fifo_wdata = in_data;
  assign fifo_last  = in_last;

  link_rx_count cnt_i (
    .clk(clk), .rst(rst), .acc(fifo_wr), .last(in_last), .src(in_src),
    .push(q_push), .desc(q_din));

  link_rx_queue #(.W(DESC_W), .DEPTH(QDEPTH)) q_i (
    .clk(clk), .rst(rst), .push(q_push), .din(q_din), .pop(q_pop),
    .dout(q_head), .empty(q_empty), .full(q_full), .level(q_level));

  link_rx_ser #(.W(DESC_W)) ser_i (
    .clk(clk), .rst(rst), .q_empty(q_empty), .q_head(q_head), .q_pop(q_pop),
    .ser_vld(ser_vld), .ser_fs(ser_fs), .ser_dat(ser_dat));
endmodule

// File: rtl/link_rx_desc_chk.sv
module link_rx_desc_chk #(
  parameter int DEST_W = 4,
  parameter int MY_ID  = 1
) (
  input logic              clk,
  input logic              rst,
  input logic              in_valid,
  input logic [DEST_W-1:0] in_dest,
  input logic              hold_up,
  input logic              fifo_wr,
  input logic              out_valid,
  input logic              q_push,
  input logic              q_full,
  input logic [31:0]       q_din,
  input logic              ser_vld,
  input logic              ser_fs
);
  p_wr_needs_own_r2: assert property (@(posedge clk) disable iff (rst)
    fifo_wr |-> (in_valid && in_dest[MY_ID]));

  p_hold_blocks_r4: assert property (@(posedge clk) disable iff (rst)
    hold_up |-> (!fifo_wr && !out_valid));

  p_desc_flag_r6: assert property (@(posedge clk) disable iff (rst)
    q_push |-> (q_din[31] && q_din[30:20] == 11'd0));

  p_no_overflow_r8: assert property (@(posedge clk) disable iff (rst)
    q_full |-> !q_push);

  p_fs_single_r9: assert property (@(posedge clk) disable iff (rst)
    ser_fs |=> (ser_vld && !ser_fs));

  p_frame_start_r9: assert property (@(posedge clk) disable iff (rst)
    $rose(ser_vld) |-> ser_fs);
endmodule

bind link_rx_desc link_rx_desc_chk #(.DEST_W(DEST_W), .MY_ID(MY_ID)) chk_i (
  .clk(clk), .rst(rst), .in_valid(in_valid), .in_dest(in_dest), .hold_up(hold_up),
  .fifo_wr(fifo_wr), .out_valid(out_valid), .q_push(q_push), .q_full(q_full),
  .q_din(q_din), .ser_vld(ser_vld), .ser_fs(ser_fs));

// File: tb/link_rx_desc_tb.sv
module link_rx_desc_tb_top;
  logic clk = 0;
  logic rst = 1;
  always #5 clk = ~clk;

  logic in_valid = 0, in_last = 0, dn_hold = 0, fifo_afull = 0;
  logic [31:0] in_data = 0;
  logic [3:0]  in_dest = 0, in_src = 0;
  logic hold_up, out_valid, out_last, fifo_wr, fifo_last, ser_vld, ser_fs, ser_dat;
  logic [31:0] out_data, fifo_wdata;
  logic [3:0]  out_dest, out_src;

  link_rx_desc dut_i (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data), .in_dest(in_dest),
    .in_src(in_src), .in_last(in_last), .hold_up(hold_up), .out_valid(out_valid),
    .out_data(out_data), .out_dest(out_dest), .out_src(out_src), .out_last(out_last),
    .dn_hold(dn_hold), .fifo_wr(fifo_wr), .fifo_wdata(fifo_wdata), .fifo_last(fifo_last),
    .fifo_afull(fifo_afull), .ser_vld(ser_vld), .ser_fs(ser_fs), .ser_dat(ser_dat));

  localparam logic [3:0] OWN = 4'b0010;   // MY_ID = 1
  localparam logic [3:0] OTH = 4'b1101;

  int checks = 0, errors = 0;
  logic [31:0] exp_q [0:63];
  logic [31:0] cap_q [0:63];
  int exp_n = 0, cap_n = 0;
  logic [15:0] bcnt = 0;
  bit seen_hold = 0;
  bit done = 0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // Serial capture, 2 ns after each rising edge.
  logic [31:0] sh = 0;
  int nb = 0;
  always @(posedge clk) begin
    #2;
    if (ser_vld) begin
      if (ser_fs) nb = 0;
      sh = {sh[30:0], ser_dat};
      nb++;
      if (nb == 32 && cap_n < 64) begin
        cap_q[cap_n] = sh;
        cap_n++;
      end
    end
  end

  // Drive one word; wait while held; check the combinational outputs; update the model.
  task automatic send(input logic [3:0] d, input logic [3:0] s, input logic l, input logic [31:0] w);
    @(negedge clk);
    in_valid = 1; in_dest = d; in_src = s; in_last = l; in_data = w;
    #1;
    while (hold_up) begin
      seen_hold = 1;
      chk(!fifo_wr && !out_valid, "R4 held word moves", {fifo_wr, out_valid}, 0);
      @(negedge clk); #1;
    end
    chk(fifo_wr == d[1], "R2 fifo_wr", fifo_wr, d[1]);
    if (d[1]) chk(fifo_wdata == w, "R2 fifo_wdata", fifo_wdata, w);
    chk(out_valid == |(d & OTH), "R3 out_valid", out_valid, |(d & OTH));
    if (|(d & OTH)) chk(out_dest == (d & OTH) && out_data == w, "R3 out_dest", out_dest, d & OTH);
    @(posedge clk);
    if (d[1]) begin
      if (bcnt != 16'hFFFF) bcnt = bcnt + 1;
      if (l) begin
        exp_q[exp_n] = {1'b1, 11'd0, s, bcnt};
        exp_n++;
        bcnt = 0;
      end
    end
    #1 in_valid = 0;
  endtask

  // Vector table: dest, src, last, data.
  localparam int NV = 10;
  localparam logic [40:0] VEC [NV] = '{
    {4'b0010, 4'h0, 1'b0, 32'hA000_0001},
    {4'b0010, 4'h0, 1'b1, 32'hA000_0002},
    {4'b0100, 4'h1, 1'b0, 32'hB000_0001},
    {4'b0110, 4'h2, 1'b0, 32'hC000_0001},
    {4'b0001, 4'h2, 1'b1, 32'hC000_0002},
    {4'b0010, 4'h2, 1'b0, 32'hC000_0003},
    {4'b1010, 4'h2, 1'b1, 32'hC000_0004},
    {4'b1000, 4'h3, 1'b1, 32'hD000_0001},
    {4'b0010, 4'h5, 1'b1, 32'hE000_0001},
    {4'b1111, 4'hF, 1'b1, 32'hF000_0001}
  };

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst = 0;
    @(negedge clk);
    // R1 reset state
    chk(!hold_up && !out_valid && !fifo_wr && !ser_vld, "R1 reset outputs",
        {hold_up, out_valid, fifo_wr, ser_vld}, 0);

    // R10 latency from the closing word to the first serial bit
    send(OWN, 4'h7, 1'b1, 32'h1234_5678);
    chk(ser_vld == 0, "R10 not yet started", ser_vld, 0);
    @(posedge clk); #2;
    chk(ser_fs && ser_vld, "R10 first bit timing", {ser_fs, ser_vld}, 2'b11);
    chk(ser_dat == 1'b1, "R9 MSB first", ser_dat, 1);
    @(posedge clk); #2;
    chk(ser_vld && !ser_fs, "R9 fs only on first bit", {ser_vld, ser_fs}, 2'b10);

    // Table walk
    for (int i = 0; i < NV; i++)
      send(VEC[i][40:37], VEC[i][36:33], VEC[i][32], VEC[i][31:0]);

    // R4 hold directed cases, all within one low phase
    @(negedge clk);
    fifo_afull = 1; in_valid = 1; in_dest = OWN; in_last = 1; in_src = 4'h9;
    #1 chk(hold_up && !fifo_wr, "R4 afull holds own word", {hold_up, fifo_wr}, 2'b10);
    in_dest = 4'b0100;
    #1 chk(!hold_up && out_valid, "R4 afull ignores pass-only word", {hold_up, out_valid}, 2'b01);
    fifo_afull = 0; dn_hold = 1;
    #1 chk(hold_up && !out_valid, "R4 dn_hold holds pass word", {hold_up, out_valid}, 2'b10);
    in_valid = 0;
    #1 chk(!hold_up, "R4 no hold without valid", hold_up, 0);
    send(OWN, 4'h9, 1'b1, 32'h0000_0099);   // own word under dn_hold is accepted
    dn_hold = 0;

    // Queue fill: back-to-back one-word blocks force the level hold
    for (int i = 0; i < 20; i++) send(OWN, 4'(i), 1'b1, 32'(i));
    chk(seen_hold, "R4 queue level hold seen", seen_hold, 1);

    // R5 saturation of a long block
    for (int i = 0; i < 65540; i++) send(OWN, 4'hC, 1'b0, 32'(i));
    send(OWN, 4'hC, 1'b1, 32'hFFFF_0000);

    repeat (40 * 24) @(posedge clk);
    @(negedge clk);
    chk(cap_n == exp_n, "R7 R8 descriptor count", cap_n, exp_n);
    for (int i = 0; i < exp_n && i < cap_n; i++)
      chk(cap_q[i] == exp_q[i], "R5 R6 R8 descriptor value", cap_q[i], exp_q[i]);
    chk(cap_n > 0 && cap_q[cap_n-1][15:0] == 16'hFFFF, "R5 saturated count",
        cap_q[cap_n-1], 32'h800C_FFFF);
    finish_run();
  end
endmodule